// File: doc/BRIEF.md
# In-Band Loop Code Generator and Detector

This block sends a short repeating bit pattern on the transmit side in place of normal line data. On the receive side it watches the incoming bit stream for two separately programmed codes, a loop-up code and a loop-down code. Each code is given as a 16-bit word made of two 8-bit halves and has its own length select. The transmit and receive sides use different length encodings. A 16-bit setting also serves any shorter pattern whose length divides 16, provided the word holds that pattern repeated.

The detector needs no alignment to the pattern's phase. On every bit it compares the received bit with the bit received one pattern length earlier. It counts these mismatches over a programmable qualification window of received bits. At the end of each window it also tests whether the most recent pattern-length bits equal some rotation of the programmed code. A qualified detection sets a latched status flag per code. Each flag can raise an interrupt through its own enable bit. When automatic loopback is enabled, the two detections drive a remote-loopback request.

Bits advance on a one-cycle `bit_en` strobe, one bit per strobe.

Top module: `inband_loopcode`

## Requirements
- R1: The transmit length select decodes 00 to 5 bits, 01 to 6, 10 to 7 and 11 to 16. The pattern word is {tx_def_a, tx_def_b}, and word bit 15 (bit 7 of tx_def_a) is sent first, followed by bits 14, 13 and so on down.
- R2: With tx_enable low, tx_line equals tx_data. With tx_enable high, tx_line carries the current pattern bit and moves to the next bit on each bit_en.
- R3: The generator returns to the first pattern bit (word bit 15) when tx_enable is low and in the cycle after tx_len_sel changes.
- R4: A receive length select decodes 000 to 110 as lengths 1 to 7 and 111 as 16. A code of length L is word bits 15 down to 16-L, with bit 15 first.
- R5: Detection is independent of phase. A window ending in any rotation of the code, arriving at any offset, counts as a match.
- R6: The detector output changes only at the end of a window of qual_len received bits, where a value of 0 counts as 1. A mismatch is a received bit that differs from the bit L bits earlier, and history starts at zero after reset. The output becomes 1 only if the window held at most ERR_TOL mismatches (default 1) and the last L bits are a rotation of the code. Otherwise it becomes 0.
- R7: A status flag is set while its detector output is 1. A flag that is already set stays set until its clear strobe arrives while the detector output is 0, and setting wins over clearing.
- R8: irq is 1 exactly when some flag is set and that flag's interrupt enable is 1. An enable of 0 masks the flag.
- R9: With auto_lb_en high, a loop-down detection drops remote_lb and takes priority. Otherwise a loop-up detection raises remote_lb, and with neither detection remote_lb holds its value. With auto_lb_en low, remote_lb is 0.
- R10: After reset, both detector outputs, both flags, irq and remote_lb are 0, and the generator stands at the first pattern bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| tx_data | input | 1 | Normal transmit data |
| tx_enable | input | 1 | Send pattern in place of tx_data |
| tx_len_sel | input | 2 | Transmit length select |
| tx_def_a | input | 8 | Transmit pattern, upper half (bit 7 first) |
| tx_def_b | input | 8 | Transmit pattern, lower half |
| tx_line | output | 1 | Transmit bit toward the line coder |
| rx_bit | input | 1 | Received data bit |
| up_len_sel | input | 3 | Loop-up code length select |
| up_def_a | input | 8 | Loop-up code, upper half |
| up_def_b | input | 8 | Loop-up code, lower half |
| dn_len_sel | input | 3 | Loop-down code length select |
| dn_def_a | input | 8 | Loop-down code, upper half |
| dn_def_b | input | 8 | Loop-down code, lower half |
| qual_len | input | QW | Qualification window length in bits |
| up_clr | input | 1 | Clear strobe for the loop-up flag |
| dn_clr | input | 1 | Clear strobe for the loop-down flag |
| up_irq_en | input | 1 | Interrupt enable for the loop-up flag |
| dn_irq_en | input | 1 | Interrupt enable for the loop-down flag |
| auto_lb_en | input | 1 | Let detections drive remote loopback |
| up_det | output | 1 | Qualified loop-up detection |
| dn_det | output | 1 | Qualified loop-down detection |
| up_flag | output | 1 | Latched loop-up status |
| dn_flag | output | 1 | Latched loop-down status |
| irq | output | 1 | Interrupt request |
| remote_lb | output | 1 | Remote loopback request |

## Verification
The hardest states to reach from the ports sit at the edge of the error tolerance. One case is a window holding exactly ERR_TOL mismatches that must still qualify. Another is a window whose mismatch count is inside tolerance but whose closing bits are a rotation of the wrong code. Random trials start the code at a random phase, choose the length selects and window sizes at random, and sometimes flip a bit in the received pattern at a low rate, so windows with zero, one and two errors all occur. A bench model of the window rules sets the expected output after every bit. Directed runs of a 16-bit word that holds an 8-bit pattern push remote_lb up and then back down.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int CODE_W = 16;

  // transmit length select -> pattern length in bits
  function automatic logic [4:0] tx_len_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd5;
      2'b01:   return 5'd6;
      2'b10:   return 5'd7;
      default: return 5'd16;
    endcase
  endfunction

  // receive length select -> pattern length in bits
  function automatic logic [4:0] rx_len_of(input logic [2:0] sel);
    return (sel == 3'b111) ? 5'd16 : ({2'b00, sel} + 5'd1);
  endfunction

  // idx-th bit on the line, counting from word bit 15
  function automatic logic code_bit(input logic [15:0] code, input logic [3:0] idx);
    return code[4'd15 - idx];
  endfunction

  // win holds received bits, bit 0 newest. True when the last len bits
  // (oldest first) equal the code started at some rotation.
  function automatic logic rot_match(input logic [15:0] win,
                                     input logic [15:0] code,
                                     input logic [4:0]  len);
    logic hit;
    logic ok;
    int   j;
    logic [3:0] wi;
    logic [3:0] ci;
    hit = 1'b0;
    for (int r = 0; r < CODE_W; r++) begin
      ok = (r < int'(len));
      for (int i = 0; i < CODE_W; i++) begin
        if (i < int'(len)) begin
          j = i + r;
          if (j >= int'(len)) j = j - int'(len);
          wi = 4'(int'(len) - 1 - i);
          ci = 4'(15 - j);
          if (win[wi] != code[ci]) ok = 1'b0;
        end
      end
      hit = hit | ok;
    end
    return hit;
  endfunction

endpackage

// File: rtl/lc_pattern_gen.sv
module lc_pattern_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        enable,
  input  logic [1:0]  len_sel,
  input  logic [15:0] code,
  input  logic        data_in,
  output logic        line_out
);
  logic [4:0] len;
  logic [3:0] pos;
  logic [1:0] sel_q;
  logic       restart;
  logic       wrap;

  assign len     = lc_pkg::tx_len_of(len_sel);
  assign restart = !enable || (len_sel != sel_q);
  assign wrap    = ({1'b0, pos} == (len - 5'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= len_sel;
      if (restart)     pos <= '0;
      else if (bit_en) pos <= wrap ? 4'd0 : pos + 4'd1;
    end
  end

  assign line_out = enable ? lc_pkg::code_bit(code, pos) : data_in;

  // position never leaves the selected length once the select is steady
  p_pos_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(len_sel) |-> ({1'b0, pos} < len));
  p_restart_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pos == 4'd0));
  p_restart_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_sel) |=> (pos == 4'd0));
endmodule

// File: rtl/lc_code_detect.sv
module lc_code_detect #(
  parameter int QW      = 8,
  parameter int ERR_TOL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic [2:0]    len_sel,
  input  logic [15:0]   code,
  input  logic [QW-1:0] qual_len,
  output logic          det
);
  localparam int EW = $clog2(ERR_TOL + 2);
  localparam logic [EW-1:0] ERR_SAT = EW'(ERR_TOL + 1);
  localparam logic [EW-1:0] ERR_MAX = EW'(ERR_TOL);

  logic [15:0]   hist;
  logic [15:0]   hist_nx;
  logic [4:0]    len;
  logic          mism;
  logic          win_end;
  logic          win_ok;
  logic [QW-1:0] cnt;
  logic [QW:0]   cnt_p1;
  logic [EW-1:0] errs;
  logic [EW-1:0] errs_nx;

  assign len     = lc_pkg::rx_len_of(len_sel);
  assign hist_nx = {hist[14:0], rx_bit};
  // bit received one pattern length earlier
  assign mism    = rx_bit != hist[len[3:0] - 4'd1];
  assign errs_nx = (mism && (errs != ERR_SAT)) ? errs + {{(EW-1){1'b0}}, 1'b1} : errs;
  assign cnt_p1  = {1'b0, cnt} + {{QW{1'b0}}, 1'b1};
  assign win_end = bit_en && (cnt_p1 >= {1'b0, qual_len});
  assign win_ok  = (errs_nx <= ERR_MAX) && lc_pkg::rot_match(hist_nx, code, len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      cnt  <= '0;
      errs <= '0;
      det  <= 1'b0;
    end else if (bit_en) begin
      hist <= hist_nx;
      if (win_end) begin
        cnt  <= '0;
        errs <= '0;
        det  <= win_ok;
      end else begin
        cnt  <= cnt_p1[QW-1:0];
        errs <= errs_nx;
      end
    end
  end

  p_det_only_at_window_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(det));
  p_err_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errs <= ERR_SAT);
  p_det_rise_needs_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det) |-> $past(bit_en));
endmodule

// File: rtl/lc_status.sv
module lc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic up_det,
  input  logic dn_det,
  input  logic up_clr,
  input  logic dn_clr,
  input  logic up_irq_en,
  input  logic dn_irq_en,
  input  logic auto_lb_en,
  output logic up_flag,
  output logic dn_flag,
  output logic irq,
  output logic remote_lb
);
  logic [1:0] det_v;
  logic [1:0] clr_v;
  logic [1:0] msk_v;
  logic [1:0] flag_v;

  assign det_v = {dn_det, up_det};
  assign clr_v = {dn_clr, up_clr};
  assign msk_v = {dn_irq_en, up_irq_en};

  for (genvar k = 0; k < 2; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_v[k] <= 1'b0;
      else        flag_v[k] <= det_v[k] | (flag_v[k] & ~clr_v[k]);
    end

    p_flag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      det_v[k] |=> flag_v[k]);
    p_flag_clears_only_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[k]) |-> $past(clr_v[k]));
  end

  assign up_flag = flag_v[0];
  assign dn_flag = flag_v[1];
  assign irq     = |(flag_v & msk_v);

  always_ff @(posedge clk) begin
    if (!rst_n)          remote_lb <= 1'b0;
    else if (!auto_lb_en) remote_lb <= 1'b0;
    else if (dn_det)      remote_lb <= 1'b0;
    else if (up_det)      remote_lb <= 1'b1;
  end

  p_lb_off_when_manual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_lb_en |=> !remote_lb);
  p_lb_down_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_lb_en && dn_det) |=> !remote_lb);
  p_lb_up_enters_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_lb_en && up_det && !dn_det) |=> remote_lb);
endmodule

// File: rtl/inband_loopcode.sv
module inband_loopcode #(
  parameter int QW      = 8,
  parameter int ERR_TOL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          tx_data,
  input  logic          tx_enable,
  input  logic [1:0]    tx_len_sel,
  input  logic [7:0]    tx_def_a,
  input  logic [7:0]    tx_def_b,
  output logic          tx_line,
  input  logic          rx_bit,
  input  logic [2:0]    up_len_sel,
  input  logic [7:0]    up_def_a,
  input  logic [7:0]    up_def_b,
  input  logic [2:0]    dn_len_sel,
  input  logic [7:0]    dn_def_a,
  input  logic [7:0]    dn_def_b,
  input  logic [QW-1:0] qual_len,
  input  logic          up_clr,
  input  logic          dn_clr,
  input  logic          up_irq_en,
  input  logic          dn_irq_en,
  input  logic          auto_lb_en,
  output logic          up_det,
  output logic          dn_det,
  output logic          up_flag,
  output logic          dn_flag,
  output logic          irq,
  output logic          remote_lb
);
  logic [1:0][2:0]  det_sel;
  logic [1:0][15:0] det_code;
  logic [1:0]       det_out;

  assign det_sel  = {dn_len_sel, up_len_sel};
  assign det_code = {{dn_def_a, dn_def_b}, {up_def_a, up_def_b}};

  lc_pattern_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .enable   (tx_enable),
    .len_sel  (tx_len_sel),
    .code     ({tx_def_a, tx_def_b}),
    .data_in  (tx_data),
    .line_out (tx_line)
  );

  for (genvar g = 0; g < 2; g++) begin : g_det
    lc_code_detect #(.QW(QW), .ERR_TOL(ERR_TOL)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_bit   (rx_bit),
      .len_sel  (det_sel[g]),
      .code     (det_code[g]),
      .qual_len (qual_len),
      .det      (det_out[g])
    );
  end

  assign up_det = det_out[0];
  assign dn_det = det_out[1];

  lc_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_det     (up_det),
    .dn_det     (dn_det),
    .up_clr     (up_clr),
    .dn_clr     (dn_clr),
    .up_irq_en  (up_irq_en),
    .dn_irq_en  (dn_irq_en),
    .auto_lb_en (auto_lb_en),
    .up_flag    (up_flag),
    .dn_flag    (dn_flag),
    .irq        (irq),
    .remote_lb  (remote_lb)
  );
endmodule

// File: tb/inband_loopcode_tb_top.sv
`timescale 1ns/1ps
module inband_loopcode_tb_top;
  localparam int QW  = 8;
  localparam int TOL = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, tx_data = 1'b0, tx_enable = 1'b0;
  logic [1:0] tx_len_sel = 2'b00;
  logic [7:0] tx_def_a = 8'h00, tx_def_b = 8'h00;
  logic tx_line;
  logic rx_bit = 1'b0;
  logic [2:0] up_len_sel = 3'b000, dn_len_sel = 3'b000;
  logic [7:0] up_def_a = 8'h00, up_def_b = 8'h00, dn_def_a = 8'h00, dn_def_b = 8'h00;
  logic [QW-1:0] qual_len = 8'd8;
  logic up_clr = 1'b0, dn_clr = 1'b0, up_irq_en = 1'b0, dn_irq_en = 1'b0, auto_lb_en = 1'b0;
  logic up_det, dn_det, up_flag, dn_flag, irq, remote_lb;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  inband_loopcode #(.QW(QW), .ERR_TOL(TOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data(tx_data), .tx_enable(tx_enable),
    .tx_len_sel(tx_len_sel), .tx_def_a(tx_def_a), .tx_def_b(tx_def_b), .tx_line(tx_line),
    .rx_bit(rx_bit), .up_len_sel(up_len_sel), .up_def_a(up_def_a), .up_def_b(up_def_b),
    .dn_len_sel(dn_len_sel), .dn_def_a(dn_def_a), .dn_def_b(dn_def_b), .qual_len(qual_len),
    .up_clr(up_clr), .dn_clr(dn_clr), .up_irq_en(up_irq_en), .dn_irq_en(dn_irq_en),
    .auto_lb_en(auto_lb_en), .up_det(up_det), .dn_det(dn_det), .up_flag(up_flag),
    .dn_flag(dn_flag), .irq(irq), .remote_lb(remote_lb));

  // bench model state
  logic [15:0] m_hist;
  int   m_cnt [2];
  int   m_err [2];
  logic m_det [2];
  logic m_flag [2];
  logic m_lb;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tx_len_b(input int sel);
    int t [4] = '{5, 6, 7, 16};
    return t[sel];
  endfunction

  function automatic int rx_len_b(input int sel);
    if (sel == 7) return 16;
    return sel + 1;
  endfunction

  function automatic logic nth_bit(input logic [15:0] c, input int k, input int l);
    return c[4'(15 - (k % l))];
  endfunction

  // last l received bits, read oldest to newest, equal the code read from some start
  function automatic logic is_rot(input logic [15:0] h, input logic [15:0] c, input int l);
    for (int s = 0; s < l; s++) begin
      logic same = 1'b1;
      for (int i = 0; i < l; i++)
        if (h[4'(l - 1 - i)] != nth_bit(c, s + i, l)) same = 1'b0;
      if (same) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    up_clr = 1'b0;
    dn_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_hist = '0;
    m_lb = 1'b0;
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0; m_err[k] = 0; m_det[k] = 1'b0; m_flag[k] = 1'b0;
    end
  endtask

  // one received bit followed by an idle cycle carrying optional clears
  task automatic rx_step(input logic b, input logic cu, input logic cd);
    logic [15:0] nh;
    int l;
    int q;
    logic [15:0] codes [2];
    logic clr [2];
    codes[0] = {up_def_a, up_def_b};
    codes[1] = {dn_def_a, dn_def_b};
    clr[0] = cu;
    clr[1] = cd;
    q = (int'(qual_len) == 0) ? 1 : int'(qual_len);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    up_clr = cu;
    dn_clr = cd;
    @(negedge clk);
    up_clr = 1'b0;
    dn_clr = 1'b0;
    nh = {m_hist[14:0], b};
    for (int k = 0; k < 2; k++) begin
      l = rx_len_b(int'(k == 0 ? up_len_sel : dn_len_sel));
      if (b != m_hist[4'(l - 1)]) m_err[k]++;
      m_cnt[k]++;
      if (m_cnt[k] >= q) begin
        m_det[k] = (m_err[k] <= TOL) && is_rot(nh, codes[k], l);
        m_cnt[k] = 0;
        m_err[k] = 0;
      end
      m_flag[k] = m_det[k] | (m_flag[k] & ~clr[k]);
    end
    m_hist = nh;
    if (!auto_lb_en) m_lb = 1'b0;
    else if (m_det[1]) m_lb = 1'b0;
    else if (m_det[0]) m_lb = 1'b1;
    check("R5 R6 up_det", 32'(up_det), 32'(m_det[0]));
    check("R4 R6 dn_det", 32'(dn_det), 32'(m_det[1]));
    check("R7 up_flag", 32'(up_flag), 32'(m_flag[0]));
    check("R7 dn_flag", 32'(dn_flag), 32'(m_flag[1]));
    check("R8 irq", 32'(irq), 32'((m_flag[0] & up_irq_en) | (m_flag[1] & dn_irq_en)));
    check("R9 remote_lb", 32'(remote_lb), 32'(m_lb));
  endtask

  // mode 0: loop-up code, 1: loop-down code, 2: random, 3: loop-up with rare flips
  task automatic det_trial(input logic [2:0] us, input logic [2:0] ds,
                           input logic [15:0] uc, input logic [15:0] dc,
                           input int q, input int mode, input int nbits, input logic au);
    int ph;
    int l;
    logic b;
    logic [15:0] c;
    up_len_sel = us; dn_len_sel = ds;
    {up_def_a, up_def_b} = uc;
    {dn_def_a, dn_def_b} = dc;
    qual_len = QW'(q);
    auto_lb_en = au;
    up_irq_en = 1'($urandom);
    dn_irq_en = 1'($urandom);
    tx_enable = 1'b0;
    do_reset();
    ph = int'($urandom % 16);
    c = (mode == 1) ? dc : uc;
    l = rx_len_b(int'(mode == 1 ? ds : us));
    for (int n = 0; n < nbits; n++) begin
      if (mode == 2) b = 1'($urandom);
      else b = nth_bit(c, n + ph, l);
      if (mode == 3 && ($urandom % 20) == 0) b = ~b;
      rx_step(b, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
  endtask

  task automatic gen_trial(input int sel, input logic [15:0] c, input int sel2);
    int l;
    tx_enable = 1'b0;
    tx_len_sel = 2'(sel);
    {tx_def_a, tx_def_b} = c;
    do_reset();
    l = tx_len_b(sel);
    @(negedge clk);
    tx_data = 1'b1;
    #1 check("R2 passthrough high", 32'(tx_line), 32'd1);
    tx_data = 1'b0;
    #1 check("R2 passthrough low", 32'(tx_line), 32'd0);
    @(negedge clk);
    tx_enable = 1'b1;
    for (int k = 0; k < 3 * l + 2; k++) begin
      @(negedge clk);
      check("R1 R2 pattern bit", 32'(tx_line), 32'(nth_bit(c, k, l)));
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
    // length change mid-pattern restarts at word bit 15
    tx_len_sel = 2'(sel2);
    l = tx_len_b(sel2);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2 * l + 1; k++) begin
      check("R3 restart after length change", 32'(tx_line), 32'(nth_bit(c, k, l)));
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
    end
    // disable then enable restarts too
    tx_enable = 1'b0;
    tx_data = 1'b1;
    @(negedge clk);
    check("R2 passthrough while disabled", 32'(tx_line), 32'd1);
    tx_enable = 1'b1;
    @(negedge clk);
    check("R3 restart after enable", 32'(tx_line), 32'(c[15]));
    tx_enable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    @(negedge clk);
    check("R10 reset up_det", 32'(up_det), 32'd0);
    check("R10 reset dn_det", 32'(dn_det), 32'd0);
    check("R10 reset flags", 32'({up_flag, dn_flag}), 32'd0);
    check("R10 reset irq", 32'(irq), 32'd0);
    check("R10 reset remote_lb", 32'(remote_lb), 32'd0);
    tx_data = 1'b1;
    #1 check("R10 reset tx passthrough", 32'(tx_line), 32'd1);

    // generator: every length select, plus a mid-run length change
    for (int s = 0; s < 4; s++)
      gen_trial(s, 16'($urandom), (s + 1) % 4);
    gen_trial(3, 16'hB4B4, 0);

    // directed: 8-bit pattern carried in a 16-bit word, auto loopback up then down
    det_trial(3'b111, 3'b010, 16'hA5A5, 16'hC000, 24, 0, 80, 1'b1);
    check("R9 directed loop-up enters", 32'(remote_lb), 32'd1);
    check("R4 directed up code seen", 32'(up_det), 32'd1);
    for (int n = 0; n < 60; n++) rx_step(nth_bit(16'hC000, n, 3), 1'b0, 1'b0);
    check("R9 directed loop-down leaves", 32'(remote_lb), 32'd0);
    check("R7 up flag still latched", 32'(up_flag), 32'd1);

    // directed: window of one bit (qual 0 counts as 1) and length-1 code
    det_trial(3'b000, 3'b000, 16'h8000, 16'h0000, 0, 0, 20, 1'b0);
    check("R6 qual zero single-bit window", 32'(up_det), 32'd1);

    // random trials
    for (int t = 0; t < 40; t++)
      det_trial(3'($urandom), 3'($urandom), 16'($urandom), 16'($urandom),
                8 + int'($urandom % 40), int'($urandom % 4), 60 + int'($urandom % 60),
                1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule